// File: doc/BRIEF.md
# CAN Message Acceptance Filter

This block picks the stored message object that takes a CAN frame once the frame has been completely received. It holds fifteen object slots. Each slot keeps an identifier, a valid bit, a direction bit (transmit or receive) and a bit that says whether it expects an extended or a standard frame. When the receiver strobes `frame_done` with the received identifier, the frame type and the remote flag, the filter looks for a match in two stages. The first stage compares the identifier against objects 1 to 14 under a shared mask. There is one shared mask for 11-bit identifiers and another for 29-bit identifiers. A mask bit of 0 makes that identifier bit don't-care.

Object 15 is the fallback, and it only receives. It is tried only when the first stage finds nothing, and it uses its own local mask. A frame that object 15 accepts is held in a two-deep buffer, which gives the host time to read the previous frame. When a remote frame hits a transmit object, the filter raises a request for the transmitter to send that object's data frame. A data frame accepted by a receive object sets that object's receive interrupt flag. The host configures the block through a simple write port.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `hit`, `hit_idx`, `reply_req`, `rx_irq`, `lc_valid`, `lc_pending` and `lc_overrun` are all zero. Every object is invalid, and all mask bits are 1.
- R2: Objects 1 to 14 match when `((obj_id ^ rx_id) & mask) == 0`. A standard frame (`rx_ext`=0) uses the 11-bit standard mask on `rx_id[10:0]`. An extended frame uses the 29-bit extended mask on `rx_id[28:0]`.
- R3: An object accepts a frame only when its extended-configuration bit equals `rx_ext`.
- R4: An object whose valid bit is clear never matches. When several of objects 1 to 14 match, the lowest-numbered one wins.
- R5: Object 15 is compared only when none of objects 1 to 14 matches. It uses its local mask, limited to the low 11 bits for standard frames, and it accepts only data frames (`rx_rtr`=0).
- R6: A data frame can only match receive objects (direction bit 0), and a remote frame can only match transmit objects (direction bit 1). A remote-frame hit raises `reply_req` together with `hit`.
- R7: The decision appears on the clock edge that samples `frame_done`. `hit` is then high for one cycle, and `hit_idx` carries the object number (1 to 15). Without a hit, `hit` is low and `hit_idx` is 0.
- R8: A data-frame hit on object n sets `rx_irq[n-1]`. Writing 1s to the interrupt-clear register clears the matching bits. A set in the same cycle takes precedence over a clear.
- R9: Object 15 holds up to two frames. The first goes to the host-visible slot (`lc_valid`, `lc_id`, `lc_ext`) and the second goes to the pending slot (`lc_pending`). A write to the release register moves the pending frame forward, or empties the visible slot if nothing is pending.
- R10: If object 15 accepts a frame while both slots are full, the new frame replaces the pending one and `lc_overrun` is set. A release clears `lc_overrun`.
- R11: Write addresses: 0 is the standard mask (data[10:0]), 1 is the extended mask (data[28:0]), 2 is the object-15 local mask (data[28:0]), 3 is the interrupt clear (write 1s), and 4 is the release. Addresses 16+k configure object k+1, with valid in bit 31, transmit in bit 30, extended in bit 29 and the identifier in bits 28:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 32 | Host write data |
| frame_done | input | 1 | One-cycle strobe: a frame has been received |
| rx_id | input | 29 | Received identifier, right-aligned |
| rx_ext | input | 1 | 1 for an extended-identifier frame |
| rx_rtr | input | 1 | 1 for a remote frame |
| hit | output | 1 | One-cycle acceptance pulse |
| hit_idx | output | IDX_W | Number of the accepting object, 0 when there is no hit |
| reply_req | output | 1 | Request to send the data frame of the hit transmit object |
| rx_irq | output | NUM_OBJ | Per-object receive interrupt flags |
| lc_valid | output | 1 | The object-15 visible slot holds a frame |
| lc_id | output | 29 | Identifier in the object-15 visible slot |
| lc_ext | output | 1 | Frame type in the object-15 visible slot |
| lc_pending | output | 1 | The object-15 second slot holds a frame |
| lc_overrun | output | 1 | An object-15 frame was overwritten |

## Verification
The bench builds the block with its default values: fifteen objects and a six-bit write address. At that size the fallback object sits at index 15, which is also the largest value `hit_idx` can show, so the boundary between the two matching stages is exercised at full scale. The same size lets one pass reach the priority conflict between neighbouring objects, the split between the standard and extended masks, and the complete fill, overrun and drain sequence of the fallback buffer.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  typedef struct packed {
    logic            valid;
    logic            tx;
    logic            ext;
    logic [ID_W-1:0] id;
  } obj_cfg_t;
endpackage

// File: rtl/can_af_regs.sv
module can_af_regs
  import can_af_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ADDR_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [31:0]             wr_data,
  output obj_cfg_t [NUM_OBJ-1:0]  cfg,
  output logic [ID_W-1:0]         gmask_std,
  output logic [ID_W-1:0]         gmask_ext,
  output logic [ID_W-1:0]         lmask,
  output logic [NUM_OBJ-1:0]      irq_clr,
  output logic                    rel
);
  localparam int A_STD    = 0;
  localparam int A_EXT    = 1;
  localparam int A_LOC    = 2;
  localparam int A_CLR    = 3;
  localparam int A_REL    = 4;
  localparam int OBJ_BASE = 16;
  localparam logic [ID_W-1:0] STD_FIELD = ID_W'((1 << STD_W) - 1);
  localparam logic [ID_W-1:0] ALL_ONES  = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask_std <= STD_FIELD;
      gmask_ext <= ALL_ONES;
      lmask     <= ALL_ONES;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_STD)) gmask_std <= wr_data[ID_W-1:0] & STD_FIELD;
      if (wr_addr == ADDR_W'(A_EXT)) gmask_ext <= wr_data[ID_W-1:0];
      if (wr_addr == ADDR_W'(A_LOC)) lmask     <= wr_data[ID_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_OBJ; k++) begin
      if (rst) begin
        cfg[k] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(OBJ_BASE + k)) begin
        cfg[k] <= obj_cfg_t'(wr_data);
      end
    end
  end

  assign irq_clr = (wr_en && wr_addr == ADDR_W'(A_CLR)) ? wr_data[NUM_OBJ-1:0] : '0;
  assign rel     = wr_en && wr_addr == ADDR_W'(A_REL);
endmodule

// File: rtl/can_af_match.sv
module can_af_match
  import can_af_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int IDX_W   = 4
) (
  input  obj_cfg_t [NUM_OBJ-1:0] cfg,
  input  logic [ID_W-1:0]        gmask_std,
  input  logic [ID_W-1:0]        gmask_ext,
  input  logic [ID_W-1:0]        lmask,
  input  logic [ID_W-1:0]        rx_id,
  input  logic                   rx_ext,
  input  logic                   rx_rtr,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       idx,
  output logic                   is_reply,
  output logic                   to_last
);
  localparam int NGLOB = NUM_OBJ - 1;
  localparam logic [ID_W-1:0] STD_FIELD = ID_W'((1 << STD_W) - 1);

  logic [NGLOB-1:0] m;
  logic [ID_W-1:0]  gmask;
  logic [ID_W-1:0]  lm_eff;
  logic             m_last;
  logic             found;
  logic [IDX_W-1:0] first;

  assign gmask = rx_ext ? gmask_ext : gmask_std;

  // first stage: one comparator per object under the shared mask
  for (genvar k = 0; k < NGLOB; k++) begin : g_cmp
    assign m[k] = cfg[k].valid && (cfg[k].ext == rx_ext) && (cfg[k].tx == rx_rtr) &&
                  (((cfg[k].id ^ rx_id) & gmask) == '0);
  end

  // second stage: fallback object, receive only
  assign lm_eff = rx_ext ? lmask : (lmask & STD_FIELD);
  assign m_last = cfg[NUM_OBJ-1].valid && (cfg[NUM_OBJ-1].ext == rx_ext) && !rx_rtr &&
                  (((cfg[NUM_OBJ-1].id ^ rx_id) & lm_eff) == '0);

  always_comb begin
    found = 1'b0;
    first = '0;
    for (int k = NGLOB - 1; k >= 0; k--) begin
      if (m[k]) begin
        found = 1'b1;
        first = IDX_W'(k + 1);
      end
    end
  end

  assign to_last  = !found && m_last;
  assign any_hit  = found || m_last;
  assign idx      = found ? first : (m_last ? IDX_W'(NUM_OBJ) : '0);
  assign is_reply = found && rx_rtr;
endmodule

// File: rtl/can_af_lastbuf.sv
module can_af_lastbuf
  import can_af_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            rel,
  input  logic [ID_W-1:0] in_id,
  input  logic            in_ext,
  output logic            front_v,
  output logic [ID_W-1:0] front_id,
  output logic            front_ext,
  output logic            back_v,
  output logic            overrun
);
  logic [ID_W-1:0] back_id;
  logic            back_ext;

  logic            nf_v, nb_v, n_ovr, nf_ext, nb_ext;
  logic [ID_W-1:0] nf_id, nb_id;

  always_comb begin
    nf_v = front_v;  nf_id = front_id;  nf_ext = front_ext;
    nb_v = back_v;   nb_id = back_id;   nb_ext = back_ext;
    n_ovr = overrun;
    // release acts before a same-cycle accept
    if (rel) begin
      nf_v = back_v;  nf_id = back_id;  nf_ext = back_ext;
      nb_v = 1'b0;
      n_ovr = 1'b0;
    end
    if (accept) begin
      if (!nf_v) begin
        nf_v = 1'b1;  nf_id = in_id;  nf_ext = in_ext;
      end else begin
        if (nb_v) n_ovr = 1'b1;
        nb_v = 1'b1;  nb_id = in_id;  nb_ext = in_ext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      front_v <= 1'b0;  front_id <= '0;  front_ext <= 1'b0;
      back_v  <= 1'b0;  back_id  <= '0;  back_ext  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      front_v <= nf_v;  front_id <= nf_id;  front_ext <= nf_ext;
      back_v  <= nb_v;  back_id  <= nb_id;  back_ext  <= nb_ext;
      overrun <= n_ovr;
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_af_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ADDR_W  = 6,
  parameter int IDX_W   = $clog2(NUM_OBJ + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               frame_done,
  input  logic [28:0]        rx_id,
  input  logic               rx_ext,
  input  logic               rx_rtr,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               reply_req,
  output logic [NUM_OBJ-1:0] rx_irq,
  output logic               lc_valid,
  output logic [28:0]        lc_id,
  output logic               lc_ext,
  output logic               lc_pending,
  output logic               lc_overrun
);
  obj_cfg_t [NUM_OBJ-1:0] cfg;
  logic [ID_W-1:0]        gmask_std, gmask_ext, lmask;
  logic [NUM_OBJ-1:0]     irq_clr, irq_set;
  logic                   rel;
  logic                   any_hit, is_reply, to_last;
  logic [IDX_W-1:0]       idx;

  can_af_regs #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .gmask_std(gmask_std), .gmask_ext(gmask_ext), .lmask(lmask),
    .irq_clr(irq_clr), .rel(rel)
  );

  can_af_match #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_match (
    .cfg(cfg), .gmask_std(gmask_std), .gmask_ext(gmask_ext), .lmask(lmask),
    .rx_id(rx_id), .rx_ext(rx_ext), .rx_rtr(rx_rtr),
    .any_hit(any_hit), .idx(idx), .is_reply(is_reply), .to_last(to_last)
  );

  can_af_lastbuf u_last (
    .clk(clk), .rst(rst), .accept(frame_done && to_last), .rel(rel),
    .in_id(rx_id), .in_ext(rx_ext),
    .front_v(lc_valid), .front_id(lc_id), .front_ext(lc_ext),
    .back_v(lc_pending), .overrun(lc_overrun)
  );

  always_comb begin
    for (int k = 0; k < NUM_OBJ; k++) begin
      irq_set[k] = frame_done && any_hit && !is_reply && (idx == IDX_W'(k + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      hit_idx   <= '0;
      reply_req <= 1'b0;
      rx_irq    <= '0;
    end else begin
      hit       <= frame_done && any_hit;
      hit_idx   <= (frame_done && any_hit) ? idx : '0;
      reply_req <= frame_done && is_reply;
      rx_irq    <= (rx_irq & ~irq_clr) | irq_set;
    end
  end
endmodule

// File: rtl/can_af_chk.sv
module can_af_chk #(
  parameter int NUM_OBJ = 15,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_done,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx,
  input logic               reply_req,
  input logic [NUM_OBJ-1:0] rx_irq,
  input logic               lc_valid,
  input logic               lc_pending,
  input logic               lc_overrun
);
  // R7
  hit_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(frame_done));
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_idx != '0 && hit_idx <= IDX_W'(NUM_OBJ)));
  // R7
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> hit_idx == '0);
  // R6
  reply_has_hit_chk: assert property (@(posedge clk) disable iff (rst)
    reply_req |-> (hit && hit_idx != IDX_W'(NUM_OBJ)));
  // R8
  irq_on_rx_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !reply_req) |-> rx_irq[hit_idx - 1'b1]);
  // R9
  pending_needs_front_chk: assert property (@(posedge clk) disable iff (rst)
    lc_pending |-> lc_valid);
  // R10
  overrun_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lc_overrun) |-> lc_pending);
endmodule

bind can_accept_filter can_af_chk #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .frame_done(frame_done), .hit(hit), .hit_idx(hit_idx),
  .reply_req(reply_req), .rx_irq(rx_irq), .lc_valid(lc_valid),
  .lc_pending(lc_pending), .lc_overrun(lc_overrun)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_OBJ = 15;
  localparam int ADDR_W  = 6;
  localparam int IDX_W   = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0;
  logic [ADDR_W-1:0]  wr_addr = '0;
  logic [31:0]        wr_data = '0;
  logic               frame_done = 1'b0;
  logic [28:0]        rx_id = '0;
  logic               rx_ext = 1'b0;
  logic               rx_rtr = 1'b0;
  logic               hit, reply_req, lc_valid, lc_ext, lc_pending, lc_overrun;
  logic [IDX_W-1:0]   hit_idx;
  logic [NUM_OBJ-1:0] rx_irq;
  logic [28:0]        lc_id;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic        g_hit, g_reply;
  logic [3:0]  g_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_accept_filter #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done), .rx_id(rx_id), .rx_ext(rx_ext), .rx_rtr(rx_rtr),
    .hit(hit), .hit_idx(hit_idx), .reply_req(reply_req), .rx_irq(rx_irq),
    .lc_valid(lc_valid), .lc_id(lc_id), .lc_ext(lc_ext),
    .lc_pending(lc_pending), .lc_overrun(lc_overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  // R11 write port: addr 0 std mask, 1 ext mask, 2 local mask, 3 irq clear, 4 release, 16+k objects
  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] objw(input bit v, input bit tx, input bit ext, input logic [28:0] id);
    return {v, tx, ext, id};
  endfunction

  task automatic set_obj(input int n, input bit v, input bit tx, input bit ext, input logic [28:0] id);
    wr(16 + n - 1, objw(v, tx, ext, id));
  endtask

  task automatic send(input logic [28:0] id, input bit ext, input bit rtr);
    @(negedge clk);
    rx_id = id; rx_ext = ext; rx_rtr = rtr; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    g_hit = hit; g_idx = hit_idx; g_reply = reply_req;
    @(negedge clk);
    // R7 pulse lasts a single cycle
    expect_eq("R7 hit single cycle", {31'b0, hit}, 32'd0);
  endtask

  task automatic t_reset;
    expect_eq("R1 hit", {31'b0, hit}, 0);
    expect_eq("R1 idx", {28'b0, hit_idx}, 0);
    expect_eq("R1 reply", {31'b0, reply_req}, 0);
    expect_eq("R1 irq", {17'b0, rx_irq}, 0);
    expect_eq("R1 lc", {29'b0, lc_valid, lc_pending, lc_overrun}, 0);
    send(29'h123, 1'b0, 1'b0);
    expect_eq("R4 invalid objects never hit", {31'b0, g_hit}, 0);
    expect_eq("R7 idx zero without hit", {28'b0, g_idx}, 0);
  endtask

  task automatic t_global;
    set_obj(1, 1, 0, 0, 29'h123);
    send(29'h123, 0, 0);
    expect_eq("R2 exact hit", {31'b0, g_hit}, 1);
    expect_eq("R7 idx obj1", {28'b0, g_idx}, 1);
    send(29'h124, 0, 0);
    expect_eq("R2 mismatch", {31'b0, g_hit}, 0);
    wr(0, 32'h7F0);
    send(29'h12F, 0, 0);
    expect_eq("R2 dont-care low bits", {28'b0, g_idx}, 1);
    send(29'h133, 0, 0);
    expect_eq("R2 cared bit differs", {31'b0, g_hit}, 0);
    wr(0, 32'h7FF);
  endtask

  task automatic t_irq;
    expect_eq("R8 irq set obj1", {17'b0, rx_irq}, 32'h1);
    wr(3, 32'h1);
    expect_eq("R8 irq cleared", {17'b0, rx_irq}, 0);
  endtask

  task automatic t_ext;
    set_obj(2, 1, 0, 1, 29'h1ABCDE12);
    send(29'h123, 1, 0);
    expect_eq("R3 ext frame vs std object", {31'b0, g_hit}, 0);
    send(29'h1ABCDE12, 1, 0);
    expect_eq("R3 ext hit", {28'b0, g_idx}, 2);
    wr(1, 32'h1FFFFFF0);
    send(29'h1ABCDE1F, 1, 0);
    expect_eq("R2 ext mask dont-care", {28'b0, g_idx}, 2);
    send(29'h12F, 0, 0);
    expect_eq("R2 std mask separate", {31'b0, g_hit}, 0);
    wr(1, 32'h1FFFFFFF);
  endtask

  task automatic t_priority;
    set_obj(3, 1, 0, 0, 29'h200);
    set_obj(4, 1, 0, 0, 29'h200);
    send(29'h200, 0, 0);
    expect_eq("R4 lowest wins", {28'b0, g_idx}, 3);
    set_obj(3, 0, 0, 0, 29'h200);
    send(29'h200, 0, 0);
    expect_eq("R4 invalid skipped", {28'b0, g_idx}, 4);
  endtask

  task automatic t_remote;
    set_obj(5, 1, 1, 0, 29'h300);
    wr(3, 32'h7FFF);
    send(29'h300, 0, 1);
    expect_eq("R6 remote hit", {31'b0, g_hit}, 1);
    expect_eq("R6 remote idx", {28'b0, g_idx}, 5);
    expect_eq("R6 reply req", {31'b0, g_reply}, 1);
    expect_eq("R8 no irq on reply", {31'b0, rx_irq[4]}, 0);
    send(29'h300, 0, 0);
    expect_eq("R6 data to tx object", {31'b0, g_hit}, 0);
    send(29'h200, 0, 1);
    expect_eq("R6 remote to rx object", {30'b0, g_hit, g_reply}, 0);
  endtask

  task automatic t_last;
    set_obj(15, 1, 0, 0, 29'h400);
    wr(2, 32'h700);
    send(29'h4CD, 0, 0);
    expect_eq("R5 fallback idx", {28'b0, g_idx}, 15);
    expect_eq("R9 front filled", {31'b0, lc_valid}, 1);
    expect_eq("R9 front id", {3'b0, lc_id}, 32'h4CD);
    expect_eq("R8 irq obj15", {31'b0, rx_irq[14]}, 1);
    set_obj(6, 1, 0, 0, 29'h4AB);
    send(29'h4AB, 0, 0);
    expect_eq("R5 first stage precedence", {28'b0, g_idx}, 6);
    expect_eq("R5 buffer untouched", {31'b0, lc_pending}, 0);
    send(29'h4EE, 0, 1);
    expect_eq("R5 remote not taken", {31'b0, g_hit}, 0);
    send(29'h455, 0, 0);
    expect_eq("R9 pending set", {31'b0, lc_pending}, 1);
    expect_eq("R9 front kept", {3'b0, lc_id}, 32'h4CD);
    expect_eq("R10 no overrun yet", {31'b0, lc_overrun}, 0);
    send(29'h466, 0, 0);
    expect_eq("R10 overrun set", {31'b0, lc_overrun}, 1);
    wr(4, 32'h0);
    expect_eq("R10 newer kept", {3'b0, lc_id}, 32'h466);
    expect_eq("R10 overrun cleared", {31'b0, lc_overrun}, 0);
    expect_eq("R9 pending drained", {31'b0, lc_pending}, 0);
    wr(4, 32'h0);
    expect_eq("R9 front emptied", {31'b0, lc_valid}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_global;
    t_irq;
    t_ext;
    t_priority;
    t_remote;
    t_last;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule